// File: doc/BRIEF.md
# Clock Source Start-up and Switching Controller

This controller decides which oscillator source clocks the system and steps through the start-up and run-time changes of that source. It works synchronously to one system clock. It reads a set of power-on configuration fields: a two-speed start enable, a 3-bit initial source code, a 2-bit mode and a PLL-lock wait enable. It also watches a ready flag for each source, a PLL lock flag and a clock-fail flag. It accepts software requests that name a new source. It drives a 3-bit active source code, which steers an external glitch-free clock multiplexer, together with a switch-busy flag and a sticky fail status bit.

Source codes are: 000 internal fast RC, 001 fast RC with PLL, 010 primary, 011 primary with PLL, 100 secondary low-power, 101 low-power RC, 111 fast RC with postscaler. Code 110 is reserved. The mode field works as follows. With bit 1 set, software switching and the fail-safe monitor are both off. Value 01 permits software switching only. Value 00 permits software switching and also turns on the fail-safe fallback.

The controller is a state machine with four states. BOOT is the first cycle after reset. RUN is the steady state. WAIT_RDY waits for the target source's ready flag. WAIT_LOCK waits for PLL lock. The transitions are:
- T_BOOT_DIRECT: BOOT to RUN, loading the configured source.
- T_BOOT_SLOW: BOOT to WAIT_RDY, when two-speed start is set.
- T_REQ_ACCEPT: RUN to WAIT_RDY, when a software request is accepted.
- T_READY_HOLD: WAIT_RDY to WAIT_LOCK, when the target is ready but lock is still needed.
- T_READY_COMMIT: WAIT_RDY to RUN, committing the target.
- T_LOCK_COMMIT: WAIT_LOCK to RUN, committing the target.
- T_FAILOVER: from any state to RUN on source 000.

Top module: `clk_src_ctrl`

## Requirements
- R1: While reset is asserted, active_src is 000, switch_busy is 0 and fail_status is 0.
- R2: With two-speed start set and a configured source other than 000, the controller stays on 000 after reset with switch_busy high. It moves to the configured source on the clock edge that sees that source's ready flag (src_ready indexed by source code) high, and switch_busy drops on the same edge.
- R3: With two-speed start clear, or the configured source equal to 000, active_src takes the configured source on the first clock edge after reset release, and switch_busy stays low. A configured code of 110 starts on 000.
- R4: With mode bit 1 set, software requests are dropped, switch_busy stays low, and clk_fail has no effect on active_src or fail_status.
- R5: With mode 01, requests are accepted, and clk_fail leaves active_src unchanged and fail_status low.
- R6: With mode 00, clk_fail sampled high forces active_src to 000 and sets fail_status on that edge. This has priority in every state and also ends a switch in progress. fail_status then stays set until reset.
- R7: An accepted request raises switch_busy on the edge that samples it. The new source becomes active, and switch_busy falls, on the first edge in WAIT_RDY where the target's ready flag is high and no lock wait applies.
- R8: A request for code 110 is ignored: switch_busy stays low and active_src is unchanged.
- R9: With cfg_pll_wait set, a switch to 001 or 011 that finds the target ready but pll_locked low waits in WAIT_LOCK. It commits on the edge that sees pll_locked high. With cfg_pll_wait clear, it commits on ready alone.
- R10: Requests arriving while switch_busy is high are ignored; the target of the switch in progress is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_two_speed | input | 1 | Start on fast RC, then switch automatically |
| cfg_init_src | input | 3 | Configured start-up source code |
| cfg_mode | input | 2 | Switching / fail-safe mode |
| cfg_pll_wait | input | 1 | Hold PLL-source switches until lock |
| src_ready | input | 8 | Ready flag per source, indexed by code |
| pll_locked | input | 1 | PLL lock indication |
| clk_fail | input | 1 | Clock failure indication |
| req_valid | input | 1 | Software switch request strobe |
| req_src | input | 3 | Requested source code |
| active_src | output | 3 | Currently selected source code |
| switch_busy | output | 1 | A switch is in progress |
| fail_status | output | 1 | Sticky fail-safe event flag |

## Verification
The assertions take the configuration fields to be constant from reset release until the next reset, because the controller reads them live and not from a copy. They also take the ready, lock and fail flags to be already synchronous to the system clock. The bench changes configuration only while reset is held. It drives every flag and request at the falling edge, so each value is stable across the rising edge that samples it.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    localparam int CODE_W = 3;

    localparam logic [CODE_W-1:0] SRC_FRC      = 3'b000;
    localparam logic [CODE_W-1:0] SRC_FRC_PLL  = 3'b001;
    localparam logic [CODE_W-1:0] SRC_PRI      = 3'b010;
    localparam logic [CODE_W-1:0] SRC_PRI_PLL  = 3'b011;
    localparam logic [CODE_W-1:0] SRC_SEC      = 3'b100;
    localparam logic [CODE_W-1:0] SRC_LPRC     = 3'b101;
    localparam logic [CODE_W-1:0] SRC_RSVD     = 3'b110;
    localparam logic [CODE_W-1:0] SRC_FRC_DIV  = 3'b111;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_RUN,
        ST_WAIT_RDY,
        ST_WAIT_LOCK
    } clksw_state_e;

    function automatic logic is_pll_src(input logic [CODE_W-1:0] code);
        return (code == SRC_FRC_PLL) || (code == SRC_PRI_PLL);
    endfunction

    function automatic logic is_rsvd_src(input logic [CODE_W-1:0] code);
        return code == SRC_RSVD;
    endfunction

endpackage

// File: rtl/clksw_cfg_decode.sv
module clksw_cfg_decode
    import clksw_pkg::*;
#(
    parameter int SRC_W  = 3,
    parameter int MODE_W = 2
) (
    input  logic              cfg_two_speed,
    input  logic [SRC_W-1:0]  cfg_init_src,
    input  logic [MODE_W-1:0] cfg_mode,
    output logic [SRC_W-1:0]  boot_src,
    output logic              boot_slow,
    output logic              sw_en,
    output logic              fsm_en
);

    always_comb begin
        boot_src  = is_rsvd_src(cfg_init_src) ? SRC_FRC : cfg_init_src;
        boot_slow = cfg_two_speed && (boot_src != SRC_FRC);
        sw_en     = !cfg_mode[MODE_W-1];
        fsm_en    = (cfg_mode == '0);
    end

endmodule

// File: rtl/clksw_req_gate.sv
module clksw_req_gate
    import clksw_pkg::*;
#(
    parameter int SRC_W = 3,
    localparam int N_SRC = 1 << SRC_W
) (
    input  logic             req_valid,
    input  logic [SRC_W-1:0] req_src,
    input  logic             sw_en,
    input  logic             in_run,
    input  logic [SRC_W-1:0] tgt_src,
    input  logic [N_SRC-1:0] src_ready,
    input  logic             cfg_pll_wait,
    output logic             accept,
    output logic             tgt_ready,
    output logic             need_lock
);

    logic [N_SRC-1:0] hit;

    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_sel
            assign hit[i] = src_ready[i] && (tgt_src == SRC_W'(i));
        end
    endgenerate

    always_comb begin
        accept    = req_valid && sw_en && in_run && !is_rsvd_src(req_src);
        tgt_ready = |hit;
        need_lock = cfg_pll_wait && is_pll_src(tgt_src);
    end

endmodule

// File: rtl/clksw_fail_latch.sv
module clksw_fail_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_evt,
    output logic fail_status
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_status <= 1'b0;
        end else if (fail_evt) begin
            fail_status <= 1'b1;
        end
    end

endmodule

// File: rtl/clksw_fsm.sv
module clksw_fsm
    import clksw_pkg::*;
#(
    parameter int SRC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] boot_src,
    input  logic             boot_slow,
    input  logic             accept,
    input  logic [SRC_W-1:0] req_src,
    input  logic             tgt_ready,
    input  logic             need_lock,
    input  logic             pll_locked,
    input  logic             fail_evt,
    output clksw_state_e     state_q,
    output logic [SRC_W-1:0] tgt_q,
    output logic [SRC_W-1:0] active_q,
    output logic             busy_q
);

    clksw_state_e     state_d;
    logic [SRC_W-1:0] tgt_d;
    logic [SRC_W-1:0] active_d;

    // next-state and next-value decision
    always_comb begin
        state_d  = state_q;
        tgt_d    = tgt_q;
        active_d = active_q;
        unique case (state_q)
            ST_BOOT: begin
                if (fail_evt) begin                 // T_FAILOVER
                    state_d  = ST_RUN;
                    active_d = SRC_FRC;
                end else if (boot_slow) begin       // T_BOOT_SLOW
                    state_d  = ST_WAIT_RDY;
                    tgt_d    = boot_src;
                    active_d = SRC_FRC;
                end else begin                      // T_BOOT_DIRECT
                    state_d  = ST_RUN;
                    active_d = boot_src;
                end
            end
            ST_RUN: begin
                if (fail_evt) begin                 // T_FAILOVER
                    active_d = SRC_FRC;
                end else if (accept) begin          // T_REQ_ACCEPT
                    state_d = ST_WAIT_RDY;
                    tgt_d   = req_src;
                end
            end
            ST_WAIT_RDY: begin
                if (fail_evt) begin                 // T_FAILOVER
                    state_d  = ST_RUN;
                    active_d = SRC_FRC;
                end else if (tgt_ready) begin
                    if (need_lock && !pll_locked) begin
                        state_d = ST_WAIT_LOCK;     // T_READY_HOLD
                    end else begin                  // T_READY_COMMIT
                        state_d  = ST_RUN;
                        active_d = tgt_q;
                    end
                end
            end
            ST_WAIT_LOCK: begin
                if (fail_evt) begin                 // T_FAILOVER
                    state_d  = ST_RUN;
                    active_d = SRC_FRC;
                end else if (pll_locked) begin      // T_LOCK_COMMIT
                    state_d  = ST_RUN;
                    active_d = tgt_q;
                end
            end
            default: begin
                state_d  = ST_RUN;
                active_d = SRC_FRC;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q    <= SRC_FRC;
            active_q <= SRC_FRC;
            busy_q   <= 1'b0;
        end else begin
            tgt_q    <= tgt_d;
            active_q <= active_d;
            busy_q   <= (state_d == ST_WAIT_RDY) || (state_d == ST_WAIT_LOCK);
        end
    end

endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
    import clksw_pkg::*;
#(
    parameter int SRC_W  = 3,
    parameter int MODE_W = 2,
    localparam int N_SRC = 1 << SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_two_speed,
    input  logic [SRC_W-1:0]  cfg_init_src,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              cfg_pll_wait,
    input  logic [N_SRC-1:0]  src_ready,
    input  logic              pll_locked,
    input  logic              clk_fail,
    input  logic              req_valid,
    input  logic [SRC_W-1:0]  req_src,
    output logic [SRC_W-1:0]  active_src,
    output logic              switch_busy,
    output logic              fail_status
);

    logic [SRC_W-1:0] boot_src;
    logic             boot_slow;
    logic             sw_en;
    logic             fsm_en;
    logic             accept;
    logic             tgt_ready;
    logic             need_lock;
    logic             fail_evt;
    logic [SRC_W-1:0] tgt_src;
    clksw_state_e     fsm_state;

    assign fail_evt = fsm_en && clk_fail;

    clksw_cfg_decode #(.SRC_W(SRC_W), .MODE_W(MODE_W)) u_cfg (
        .cfg_two_speed (cfg_two_speed),
        .cfg_init_src  (cfg_init_src),
        .cfg_mode      (cfg_mode),
        .boot_src      (boot_src),
        .boot_slow     (boot_slow),
        .sw_en         (sw_en),
        .fsm_en        (fsm_en)
    );

    clksw_req_gate #(.SRC_W(SRC_W)) u_gate (
        .req_valid    (req_valid),
        .req_src      (req_src),
        .sw_en        (sw_en),
        .in_run       (fsm_state == ST_RUN),
        .tgt_src      (tgt_src),
        .src_ready    (src_ready),
        .cfg_pll_wait (cfg_pll_wait),
        .accept       (accept),
        .tgt_ready    (tgt_ready),
        .need_lock    (need_lock)
    );

    clksw_fsm #(.SRC_W(SRC_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_src   (boot_src),
        .boot_slow  (boot_slow),
        .accept     (accept),
        .req_src    (req_src),
        .tgt_ready  (tgt_ready),
        .need_lock  (need_lock),
        .pll_locked (pll_locked),
        .fail_evt   (fail_evt),
        .state_q    (fsm_state),
        .tgt_q      (tgt_src),
        .active_q   (active_src),
        .busy_q     (switch_busy)
    );

    clksw_fail_latch u_fail (
        .clk         (clk),
        .rst_n       (rst_n),
        .fail_evt    (fail_evt),
        .fail_status (fail_status)
    );

endmodule

// File: rtl/clksw_chk.sv
module clksw_chk
    import clksw_pkg::*;
#(
    parameter int SRC_W  = 3,
    parameter int MODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] cfg_mode,
    input logic              cfg_pll_wait,
    input logic              pll_locked,
    input logic              clk_fail,
    input logic [SRC_W-1:0]  active_src,
    input logic              switch_busy,
    input logic              fail_status,
    input logic [SRC_W-1:0]  tgt_src,
    input clksw_state_e      fsm_state
);

    AST_NO_RESERVED_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        active_src != SRC_RSVD);  // R8

    AST_LOCKED_MODE_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode[MODE_W-1] && !switch_busy && fsm_state != ST_BOOT) |=> !switch_busy);  // R4

    AST_FAIL_TO_FRC: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == '0 && clk_fail) |=> (active_src == SRC_FRC && fail_status && !switch_busy));  // R6

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fail_status |=> fail_status);  // R6

    AST_NO_FAIL_WITHOUT_MONITOR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode != '0) |-> !fail_status);  // R5

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pll_wait && switch_busy && is_pll_src(tgt_src) && !pll_locked
         && !(cfg_mode == '0 && clk_fail)) |=> switch_busy);  // R9

    AST_BUSY_KEEPS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        switch_busy |=> (tgt_src == $past(tgt_src)));  // R10

    AST_COMMIT_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(switch_busy) && !$past(cfg_mode == '0 && clk_fail)) |-> (active_src == tgt_src));  // R7

endmodule

bind clk_src_ctrl clksw_chk #(.SRC_W(SRC_W), .MODE_W(MODE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_mode     (cfg_mode),
    .cfg_pll_wait (cfg_pll_wait),
    .pll_locked   (pll_locked),
    .clk_fail     (clk_fail),
    .active_src   (active_src),
    .switch_busy  (switch_busy),
    .fail_status  (fail_status),
    .tgt_src      (tgt_src),
    .fsm_state    (fsm_state)
);

// File: tb/sim_clk_src_ctrl.sv
`timescale 1ns/1ps
module sim_clk_src_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_two_speed = 1'b0;
    logic [2:0] cfg_init_src = 3'd0;
    logic [1:0] cfg_mode = 2'd0;
    logic       cfg_pll_wait = 1'b0;
    logic [7:0] src_ready = 8'd0;
    logic       pll_locked = 1'b0;
    logic       clk_fail = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_src = 3'd0;
    logic [2:0] active_src;
    logic       switch_busy;
    logic       fail_status;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    clk_src_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_two_speed(cfg_two_speed),
        .cfg_init_src(cfg_init_src), .cfg_mode(cfg_mode),
        .cfg_pll_wait(cfg_pll_wait), .src_ready(src_ready),
        .pll_locked(pll_locked), .clk_fail(clk_fail), .req_valid(req_valid),
        .req_src(req_src), .active_src(active_src),
        .switch_busy(switch_busy), .fail_status(fail_status)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic boot(input bit ts, input logic [2:0] init,
                        input logic [1:0] mode, input bit pw);
        rst_n = 1'b0;
        cfg_two_speed = ts; cfg_init_src = init; cfg_mode = mode; cfg_pll_wait = pw;
        src_ready = 8'd0; pll_locked = 1'b0; clk_fail = 1'b0;
        req_valid = 1'b0; req_src = 3'd0;
        @(negedge clk); @(negedge clk);
        chk("R1 active in reset", int'(active_src), 0);
        chk("R1 busy in reset", int'(switch_busy), 0);
        chk("R1 fail in reset", int'(fail_status), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R2 / R3: start-up sweep over every configured code
        for (int ts = 0; ts < 2; ts++) begin
            for (int ini = 0; ini < 8; ini++) begin
                int eff;
                eff = (ini == 6) ? 0 : ini;
                boot(ts[0], 3'(ini), 2'b01, 1'b0);
                if (ts == 1 && eff != 0) begin
                    chk("R2 start on frc", int'(active_src), 0);
                    chk("R2 busy at start", int'(switch_busy), 1);
                    @(negedge clk);
                    chk("R2 hold until ready", int'(switch_busy), 1);
                    src_ready[eff] = 1'b1;
                    @(negedge clk);
                    chk("R2 auto switch", int'(active_src), eff);
                    chk("R2 busy cleared", int'(switch_busy), 0);
                end else begin
                    chk("R3 direct start", int'(active_src), eff);
                    chk("R3 busy low", int'(switch_busy), 0);
                end
            end
        end

        // R4 R7 R8 R9 R10: request sweep over mode, lock wait and code
        for (int md = 0; md < 4; md++) begin
            for (int pw = 0; pw < 2; pw++) begin
                for (int code = 0; code < 8; code++) begin
                    bit acc;
                    bit need;
                    int other;
                    string tg;
                    acc   = (md < 2) && (code != 6);
                    need  = (pw == 1) && (code == 1 || code == 3);
                    other = code ^ 2;
                    tg    = (md >= 2) ? "R4" : ((code == 6) ? "R8" : "R7");
                    boot(1'b0, 3'd0, 2'(md), pw[0]);
                    req_valid = 1'b1; req_src = 3'(code);
                    @(negedge clk);
                    req_valid = 1'b0;
                    chk({tg, " busy after request"}, int'(switch_busy), int'(acc));
                    chk({tg, " active after request"}, int'(active_src), 0);
                    if (acc) begin
                        req_valid = 1'b1; req_src = 3'(other);
                        src_ready = 8'd1 << other;
                        @(negedge clk);
                        req_valid = 1'b0;
                        chk("R10 still busy", int'(switch_busy), 1);
                        chk("R10 no change", int'(active_src), 0);
                        src_ready[code] = 1'b1;
                        @(negedge clk);
                        if (need) begin
                            chk("R9 wait lock active", int'(active_src), 0);
                            chk("R9 wait lock busy", int'(switch_busy), 1);
                            pll_locked = 1'b1;
                            @(negedge clk);
                        end
                        chk((code == 1 || code == 3) ? "R9 commit" : "R7 commit",
                            int'(active_src), code);
                        chk("R7 busy dropped", int'(switch_busy), 0);
                    end else begin
                        src_ready = 8'hFF;
                        repeat (3) @(negedge clk);
                        chk({tg, " ignored active"}, int'(active_src), 0);
                        chk({tg, " ignored busy"}, int'(switch_busy), 0);
                    end
                end
            end
        end

        // R4 R5 R6: clock-fail response per mode
        for (int md = 0; md < 4; md++) begin
            bit fs;
            string tg;
            fs = (md == 0);
            tg = (md == 0) ? "R6" : ((md == 1) ? "R5" : "R4");
            boot(1'b0, 3'd2, 2'(md), 1'b0);
            src_ready = 8'hFF;
            chk("R3 primary start", int'(active_src), 2);
            clk_fail = 1'b1;
            @(negedge clk);
            clk_fail = 1'b0;
            chk({tg, " fail active"}, int'(active_src), fs ? 0 : 2);
            chk({tg, " fail status"}, int'(fail_status), int'(fs));
            repeat (3) @(negedge clk);
            chk({tg, " fail status held"}, int'(fail_status), int'(fs));
        end

        // R6: failure during a pending switch
        boot(1'b0, 3'd0, 2'b00, 1'b0);
        req_valid = 1'b1; req_src = 3'd5;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 busy pending", int'(switch_busy), 1);
        clk_fail = 1'b1;
        @(negedge clk);
        clk_fail = 1'b0;
        chk("R6 abort active", int'(active_src), 0);
        chk("R6 abort busy", int'(switch_busy), 0);
        chk("R6 abort status", int'(fail_status), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule